// File: doc/BRIEF.md
# Sampling converter bus front end

This block is the digital side of a 12-bit sampling converter as a microprocessor bus sees it. A host starts a conversion with an active-low start strobe. The block holds the converter sample when the start is accepted. It reports progress on an end-of-conversion status pin that is low while busy. After a fixed latency it publishes the result. The host then reads the result from a three-state data bus, which is modelled as a data vector plus a per-line drive-enable vector.

Static straps select four things:
- whether chip-select qualifies the start and status pins;
- a full 12-bit parallel read or two byte reads from a 16-bit field;
- where the result sits inside that field;
- straight binary or twos complement coding.

The converter core is a stand-in. It is a sample input plus a cycle counter of `CONV_CYCLES` clocks.

Top module: `adc_host_if`

## Requirements
- R1: After reset the block is idle. An enabled status pin reads high. The result register holds zero. No data line is driven while the read strobes are inactive.
- R2: A qualified falling edge of `startN` (active low) starts a conversion. From the next clock edge, the status level is low for exactly `CONV_CYCLES` cycles and then returns high.
- R3: With `syncMode` = 1, `startN` and `eocEnN` take effect only while `chipSelN` is low. A start with `chipSelN` high is ignored, and the status pin is not driven.
- R4: With `syncMode` = 0, start and status enable work regardless of `chipSelN`. The status pin acts as open drain: `eocOut` is 0 and `eocOe` is 1 only while busy and enabled, and the pin is released otherwise.
- R5: The status pin is driven only while its (qualified) enable `eocEnN` is low.
- R6: Data lines are driven only while both `outEnN` and `chipSelN` are low. Otherwise `dataOe` is all zeros.
- R7: With `fmt12` = 1, all 12 lines are driven and carry the coded result.
- R8: With `fmt12` = 0, only lines 11..4 are driven and lines 3..0 read 0. `byteSel` = 0 places field bits 15..8 on lines 11..4. `byteSel` = 1 places field bits 7..0 there.
- R9: With `rightJust` = 1 the 16-bit field is {4 fill bits, code}. With `rightJust` = 0 it is {code, 4'b0000}.
- R10: With `bipolar` = 0 the code is the sample unchanged and the right-justified fill is zero. With `bipolar` = 1 the code is the sample with bit 11 inverted (twos complement), and the fill copies code bit 11.
- R11: A start while busy is ignored. The sample is captured when the start is accepted. The previous result stays readable until the new one is published.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startN | input | 1 | Start conversion, active low |
| chipSelN | input | 1 | Chip select, active low |
| outEnN | input | 1 | Read output enable, active low |
| eocEnN | input | 1 | Status pin enable, active low |
| syncMode | input | 1 | 1: chip-select gates start and status |
| fmt12 | input | 1 | 1: 12-bit parallel, 0: two byte reads |
| rightJust | input | 1 | Byte mode justification, 1: right |
| byteSel | input | 1 | Byte mode, 0: high byte, 1: low byte |
| bipolar | input | 1 | 1: twos complement coding |
| convData | input | DATA_W | Sample from the stand-in converter core |
| dataOut | output | DATA_W | Data bus value |
| dataOe | output | DATA_W | Per-line drive enable of the data bus |
| eocOut | output | 1 | End-of-conversion pin value |
| eocOe | output | 1 | End-of-conversion pin drive enable |

## Verification
The bench builds the block with `CONV_CYCLES` = 5 and the default 12-bit and 8-bit widths. The short latency lets each conversion have its status window checked cycle by cycle. It also brings the busy window close enough that a second start lands inside it. Random samples and straps are checked against every format, justification and coding. Directed cases cover the sync and async gating, the open-drain release, and the mid-scale sign inversion.

// File: rtl/adc_host_if_pkg.sv
package adc_host_if_pkg;
  typedef struct packed {
    logic startAccept;  // conversion accepted this cycle: hold the sample
    logic finish;       // last busy cycle: publish the held sample
  } ctrlStrobes_t;
endpackage

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_if_pkg::*;
#(
  parameter int CONV_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startN,
  input  logic         chipSelN,
  input  logic         eocEnN,
  input  logic         syncMode,
  output ctrlStrobes_t strobes,
  output logic         eocOut,
  output logic         eocOe
);
  localparam int CNT_W = $clog2(CONV_CYCLES + 1);

  logic             startQual;
  logic             startQualPrev;
  logic             busy;
  logic [CNT_W-1:0] remaining;
  logic             eocEnQual;

  // In sync mode chip-select gates the start request; otherwise it is free.
  assign startQual = !startN && (!syncMode || !chipSelN);
  assign eocEnQual = !eocEnN && (!syncMode || !chipSelN);

  assign strobes.startAccept = startQual && !startQualPrev && !busy;
  assign strobes.finish      = busy && (remaining == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQualPrev <= 1'b0;
      busy          <= 1'b0;
      remaining     <= '0;
    end else begin
      startQualPrev <= startQual;
      if (strobes.startAccept) begin
        busy      <= 1'b1;
        remaining <= CNT_W'(CONV_CYCLES);
      end else if (strobes.finish) begin
        busy      <= 1'b0;
        remaining <= '0;
      end else if (busy) begin
        remaining <= remaining - CNT_W'(1);
      end
    end
  end

  // Sync mode drives both levels. Async mode only ever pulls low.
  always_comb begin
    if (syncMode) begin
      eocOe  = eocEnQual;
      eocOut = !busy;
    end else begin
      eocOe  = eocEnQual && busy;
      eocOut = 1'b0;
    end
  end

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startAccept |-> !busy);  // R11
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startAccept |=> (busy && !eocOut) || !syncMode || !eocOe);  // R2
  AST_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (!syncMode && eocOe) |-> !eocOut);  // R4
  AST_EOC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    eocOe |-> !eocEnN);  // R5
  AST_SYNC_CS_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (syncMode && eocOe) |-> !chipSelN);  // R3
endmodule

// File: rtl/adc_host_datapath.sv
module adc_host_datapath
  import adc_host_if_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] convData,
  input  logic              chipSelN,
  input  logic              outEnN,
  input  logic              fmt12,
  input  logic              rightJust,
  input  logic              byteSel,
  input  logic              bipolar,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] dataOe
);
  localparam int FIELD_W = 2 * BYTE_W;
  localparam int PAD_W   = FIELD_W - DATA_W;
  localparam int LOW_W   = DATA_W - BYTE_W;

  logic [DATA_W-1:0]  holdReg;
  logic [DATA_W-1:0]  resultReg;
  logic [DATA_W-1:0]  coded;
  logic [FIELD_W-1:0] field;
  logic [BYTE_W-1:0]  byteVal;
  logic               readEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg   <= '0;
      resultReg <= '0;
    end else begin
      if (strobes.startAccept) holdReg <= convData;
      if (strobes.finish)      resultReg <= holdReg;
    end
  end

  // Twos complement of an offset-binary sample: invert the top bit.
  assign coded = bipolar ? {~resultReg[DATA_W-1], resultReg[DATA_W-2:0]} : resultReg;

  always_comb begin
    if (rightJust) field = {{PAD_W{bipolar & coded[DATA_W-1]}}, coded};
    else           field = {coded, {PAD_W{1'b0}}};
  end

  assign byteVal = byteSel ? field[BYTE_W-1:0] : field[FIELD_W-1:BYTE_W];
  assign readEn  = !outEnN && !chipSelN;

  always_comb begin
    if (!readEn) begin
      dataOut = '0;
      dataOe  = '0;
    end else if (fmt12) begin
      dataOut = coded;
      dataOe  = '1;
    end else begin
      dataOut = {byteVal, {LOW_W{1'b0}}};
      dataOe  = {{BYTE_W{1'b1}}, {LOW_W{1'b0}}};
    end
  end

  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (|dataOe) |-> (!outEnN && !chipSelN));  // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> $stable(resultReg));  // R11
  AST_BYTE_LOW_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    (!fmt12 && !outEnN && !chipSelN) |-> (dataOe[LOW_W-1:0] == '0 && $countones(dataOe) == BYTE_W));  // R8
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if
  import adc_host_if_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int BYTE_W      = 8,
  parameter int CONV_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startN,
  input  logic              chipSelN,
  input  logic              outEnN,
  input  logic              eocEnN,
  input  logic              syncMode,
  input  logic              fmt12,
  input  logic              rightJust,
  input  logic              byteSel,
  input  logic              bipolar,
  input  logic [DATA_W-1:0] convData,
  output logic [DATA_W-1:0] dataOut,
  output logic [DATA_W-1:0] dataOe,
  output logic              eocOut,
  output logic              eocOe
);
  ctrlStrobes_t strobes;

  adc_host_ctrl #(.CONV_CYCLES(CONV_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .startN(startN), .chipSelN(chipSelN),
    .eocEnN(eocEnN), .syncMode(syncMode), .strobes(strobes),
    .eocOut(eocOut), .eocOe(eocOe)
  );

  adc_host_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .convData(convData),
    .chipSelN(chipSelN), .outEnN(outEnN), .fmt12(fmt12),
    .rightJust(rightJust), .byteSel(byteSel), .bipolar(bipolar),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: tb/adc_host_if_tb_top.sv
module adc_host_if_tb_top;
  localparam int CONV = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startN = 1'b1, chipSelN = 1'b1, outEnN = 1'b1, eocEnN = 1'b1;
  logic syncMode = 1'b1, fmt12 = 1'b1, rightJust = 1'b0, byteSel = 1'b0, bipolar = 1'b0;
  logic [11:0] convData = '0;
  logic [11:0] dataOut, dataOe;
  logic eocOut, eocOe;
  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  adc_host_if #(.DATA_W(12), .BYTE_W(8), .CONV_CYCLES(CONV)) dut_i (
    .clk(clk), .rstN(rstN), .startN(startN), .chipSelN(chipSelN),
    .outEnN(outEnN), .eocEnN(eocEnN), .syncMode(syncMode), .fmt12(fmt12),
    .rightJust(rightJust), .byteSel(byteSel), .bipolar(bipolar),
    .convData(convData), .dataOut(dataOut), .dataOe(dataOe),
    .eocOut(eocOut), .eocOe(eocOe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] expBus(logic [11:0] s, logic f12, logic bip,
                                         logic rj, logic bsel);
    logic [11:0] code;
    logic [15:0] field;
    code = bip ? {~s[11], s[10:0]} : s;
    if (f12) return code;
    field = rj ? {{4{bip & code[11]}}, code} : {code, 4'h0};
    return {bsel ? field[7:0] : field[15:8], 4'h0};
  endfunction

  // Reads the current result under the present straps and checks every byte choice.
  task automatic readAll(logic [11:0] s, string req);
    @(negedge clk);
    chipSelN = 1'b0; outEnN = 1'b0;
    for (int b = 0; b < 2; b++) begin
      byteSel = b[0];
      #1;
      chk({req, " data"}, dataOut, expBus(s, fmt12, bipolar, rightJust, byteSel));
      chk("R7/R8 oe", dataOe, fmt12 ? 12'hFFF : 12'hFF0);
    end
    outEnN = 1'b1;
    #1 chk("R6 released", dataOe, 0);
  endtask

  // Sync-mode conversion with status timing checked each cycle.
  task automatic convert(logic [11:0] s);
    @(negedge clk);
    chipSelN = 1'b0; eocEnN = 1'b0; convData = s; startN = 1'b0;
    @(negedge clk);
    startN = 1'b1; convData = ~s;
    chk("R2 eoc low after start", {eocOe, eocOut}, 2'b10);
    for (int i = 1; i < CONV; i++) begin
      @(negedge clk);
      chk("R2 eoc low while busy", {eocOe, eocOut}, 2'b10);
    end
    @(negedge clk);
    chk("R2 eoc high at done", {eocOe, eocOut}, 2'b11);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++; total++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 data idle", dataOe, 0);
    chipSelN = 1'b0; eocEnN = 1'b0;
    #1 chk("R1 eoc ready", {eocOe, eocOut}, 2'b11);
    readAll(12'h000, "R1 R7");

    // R2 R7 R10 directed
    fmt12 = 1; bipolar = 0;
    convert(12'hABC);
    readAll(12'hABC, "R7 R10 unipolar");
    bipolar = 1; readAll(12'hABC, "R10 bipolar");
    fmt12 = 0; rightJust = 0; readAll(12'hABC, "R8 R9 left");
    rightJust = 1; readAll(12'hABC, "R9 R10 right sign");
    bipolar = 0; readAll(12'hABC, "R9 right zero fill");
    convert(12'h800); bipolar = 1; fmt12 = 1;
    readAll(12'h800, "R10 midscale");
    bipolar = 0;

    // R11 start while busy ignored, old result kept
    convert(12'hABC);
    @(negedge clk);
    chipSelN = 1'b0; convData = 12'h123; startN = 1'b0;
    @(negedge clk); startN = 1'b1; convData = 12'hFFF;
    @(negedge clk); startN = 1'b0;
    @(negedge clk); startN = 1'b1; outEnN = 1'b0;
    #1 chk("R11 old result during busy", dataOut, 12'hABC);
    outEnN = 1'b1;
    repeat (CONV - 3) @(negedge clk);
    chk("R11 busy unaffected by restart", eocOut, 1'b0);
    @(negedge clk);
    chk("R11 done at original time", eocOut, 1'b1);
    readAll(12'h123, "R11 held sample");
    repeat (CONV + 2) @(negedge clk);
    chk("R11 no late conversion", eocOut, 1'b1);

    // R3 sync gating
    @(negedge clk);
    syncMode = 1; chipSelN = 1'b1; eocEnN = 1'b0; convData = 12'h555; startN = 1'b0;
    #1 chk("R3 eoc off without cs", eocOe, 1'b0);
    @(negedge clk); startN = 1'b1; chipSelN = 1'b0;
    #1 chk("R3 start ignored without cs", {eocOe, eocOut}, 2'b11);
    readAll(12'h123, "R3 result unchanged");

    // R4 R5 async open drain
    @(negedge clk);
    syncMode = 0; chipSelN = 1'b1; eocEnN = 1'b0;
    #1 chk("R4 released when idle", eocOe, 1'b0);
    convData = 12'h3C5; startN = 1'b0;
    @(negedge clk); startN = 1'b1;
    chk("R4 pulls low without cs", {eocOe, eocOut}, 2'b10);
    eocEnN = 1'b1;
    #1 chk("R5 not driven without enable", eocOe, 1'b0);
    eocEnN = 1'b0;
    repeat (CONV) @(negedge clk);
    chk("R4 released at done", eocOe, 1'b0);
    fmt12 = 1; readAll(12'h3C5, "R4 async result");
    syncMode = 1;
    @(negedge clk); chipSelN = 1'b0; eocEnN = 1'b1;
    #1 chk("R5 sync eoc needs enable", eocOe, 1'b0);

    // random mixes
    for (int n = 0; n < 30; n++) begin
      logic [11:0] s;
      s = 12'($urandom);
      convert(s);
      fmt12 = 1'($urandom); bipolar = 1'($urandom); rightJust = 1'($urandom);
      readAll(s, "R7 R8 R9 R10 random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule